// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block computes the address of the next instruction word for a small microcontroller with 16-bit instruction words. Each cycle the surrounding core may present one resolved instruction. It supplies the current PC, the 8-bit status register and a two-bit transfer kind. Depending on the kind, it also supplies a status bit index with a required polarity, a short branch offset, a long jump offset, the Z pointer, and a skip request with the length of the word that would be skipped.

One clock later the unit returns the next PC and a redirect flag. The fetch stage uses the flag to drop the instruction word it fetched in sequence. Every named conditional branch (equal, carry, minus, signed greater-or-equal, half-carry, T, overflow, interrupt enable) is expressed as a status bit index plus a set-or-clear polarity. The status bit order is: carry at bit 0, zero at 1, negative at 2, overflow at 3, signed at 4, half-carry at 5, T at 6, interrupt enable at 7. For example, "branch if equal" is index 1 with polarity set.

Top module: `pcu_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `squash` and `next_pc` all become 0 after that edge.
- R2: A request sampled with `in_valid` high at edge k appears on `out_valid`, `next_pc` and `squash` after edge k; there is no other latency.
- R3: With `kind` = 0 (sequential) and `skip_req` low, `next_pc` = `cur_pc` + 1 and `squash` = 0.
- R4: With `kind` = 1 (conditional branch), the branch is taken when `status[bit_sel]` equals `want_set`. A taken branch gives `next_pc` = `cur_pc` + sign-extended 7-bit `br_off` + 1 (offset range -64..+63) and `squash` = 1.
- R5: A conditional branch that is not taken gives `next_pc` = `cur_pc` + 1 and `squash` = 0.
- R6: With `kind` = 2 (relative jump), `next_pc` = `cur_pc` + sign-extended 12-bit `jmp_off` + 1 (offset range -2048..+2047) and `squash` = 1.
- R7: With `kind` = 3 (indirect jump), `next_pc` = `z_ptr` and `squash` = 1.
- R8: With `kind` = 0 and `skip_req` high, `next_pc` = `cur_pc` + 2. If `skip_two` is high, `next_pc` = `cur_pc` + 3 instead. In both cases `squash` = 1.
- R9: `skip_req` and `skip_two` have no effect when `kind` is not 0.
- R10: All PC arithmetic wraps modulo 2^16.
- R11: A cycle with `in_valid` low gives `out_valid` = 0 and `squash` = 0 after the next edge, and `next_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A resolved instruction is present this cycle |
| kind | input | 2 | 0 sequential, 1 conditional branch, 2 relative jump, 3 indirect jump |
| cur_pc | input | 16 | Word address of the current instruction |
| status | input | 8 | Status flags, carry at bit 0 through interrupt enable at bit 7 |
| bit_sel | input | 3 | Status bit tested by a conditional branch |
| want_set | input | 1 | Polarity that takes the branch (1 = bit set) |
| br_off | input | 7 | Signed conditional branch offset |
| jmp_off | input | 12 | Signed relative jump offset |
| z_ptr | input | 16 | Indirect jump target |
| skip_req | input | 1 | The skip condition holds for this instruction |
| skip_two | input | 1 | The word to skip starts a two-word instruction |
| out_valid | output | 1 | Registered result is valid |
| next_pc | output | 16 | Registered next program counter |
| squash | output | 1 | Registered redirect flag: drop the sequentially fetched word |

## Verification
A wrong bit selection or polarity in the condition test shows as a taken branch where a fall-through was expected, or the reverse. This appears on both `next_pc` and `squash` in the cycle after the request. The bench therefore probes opposite polarities on the same flags.

An offset extended from the wrong bit shows only for negative offsets. This is why the boundary offsets -64, +63, -2048 and +2047 are driven. The same applies to a carry lost in the wrapped sum, which is why PCs near zero and near 0xFFFF are used.

A skip that leaks into a non-sequential kind corrupts the target. The error shows at the ports one cycle after the offending request.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    XK_SEQ  = 2'd0,
    XK_COND = 2'd1,
    XK_REL  = 2'd2,
    XK_IND  = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval #(
  parameter int SR_W  = 8,
  parameter int IDX_W = $clog2(SR_W)
) (
  input  logic [SR_W-1:0]  flags,
  input  logic [IDX_W-1:0] idx,
  input  logic             want_set,
  output logic             hit
);
  // One indexed bit compared against the requested polarity covers every named branch
  assign hit = (flags[idx] == want_set);
endmodule

// File: rtl/pcu_sext.sv
module pcu_sext #(
  parameter int IN_W  = 7,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_extend
      assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pcu_target_mux.sv
module pcu_target_mux
  import pcu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  xfer_kind_e       kind,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  br_ext,
  input  logic [PC_W-1:0]  jmp_ext,
  input  logic [PC_W-1:0]  z_ptr,
  input  logic             cond_hit,
  input  logic             skip_req,
  input  logic             skip_two,
  output logic [PC_W-1:0]  nxt,
  output logic             redirect
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc + PC_W'(1);

  always_comb begin
    nxt      = pc_inc;
    redirect = 1'b0;
    unique case (kind)
      XK_SEQ: begin
        if (skip_req) begin
          nxt      = skip_two ? pc + PC_W'(3) : pc + PC_W'(2);
          redirect = 1'b1;
        end
      end
      XK_COND: begin
        if (cond_hit) begin
          nxt      = pc_inc + br_ext;
          redirect = 1'b1;
        end
      end
      XK_REL: begin
        nxt      = pc_inc + jmp_ext;
        redirect = 1'b1;
      end
      XK_IND: begin
        nxt      = z_ptr;
        redirect = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcu_branch_unit.sv
module pcu_branch_unit
  import pcu_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int SR_W      = 8,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12,
  parameter int IDX_W     = $clog2(SR_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           kind,
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [SR_W-1:0]      status,
  input  logic [IDX_W-1:0]     bit_sel,
  input  logic                 want_set,
  input  logic [BR_OFF_W-1:0]  br_off,
  input  logic [JMP_OFF_W-1:0] jmp_off,
  input  logic [PC_W-1:0]      z_ptr,
  input  logic                 skip_req,
  input  logic                 skip_two,
  output logic                 out_valid,
  output logic [PC_W-1:0]      next_pc,
  output logic                 squash
);
  xfer_kind_e      kind_e;
  logic            cond_hit;
  logic [PC_W-1:0] br_ext, jmp_ext, nxt_d;
  logic            redir_d;

  assign kind_e = xfer_kind_e'(kind);

  pcu_cond_eval #(.SR_W(SR_W), .IDX_W(IDX_W)) u_cond (
    .flags(status), .idx(bit_sel), .want_set(want_set), .hit(cond_hit)
  );

  pcu_sext #(.IN_W(BR_OFF_W), .OUT_W(PC_W)) u_br_sext (
    .din(br_off), .dout(br_ext)
  );

  pcu_sext #(.IN_W(JMP_OFF_W), .OUT_W(PC_W)) u_jmp_sext (
    .din(jmp_off), .dout(jmp_ext)
  );

  pcu_target_mux #(.PC_W(PC_W)) u_mux (
    .kind(kind_e), .pc(cur_pc), .br_ext(br_ext), .jmp_ext(jmp_ext),
    .z_ptr(z_ptr), .cond_hit(cond_hit), .skip_req(skip_req),
    .skip_two(skip_two), .nxt(nxt_d), .redirect(redir_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      squash    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc <= nxt_d;
        squash  <= redir_d;
      end else begin
        squash  <= 1'b0;
      end
    end
  end

  // R11: redirect flag never appears without a valid result
  assert_squash_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
    squash |-> out_valid);

  // R11: an idle cycle holds the PC and drops the flags
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !squash && $stable(next_pc)));

  // R3: plain sequential step
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd0 && !skip_req) |=>
      (out_valid && !squash && next_pc == $past(cur_pc) + PC_W'(1)));

  // R8: skip advances by two or three words
  assert_skip_len_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd0 && skip_req) |=>
      (squash && next_pc == $past(cur_pc) + ($past(skip_two) ? PC_W'(3) : PC_W'(2))));

  // R7 and R9: indirect target is Z regardless of the skip inputs
  assert_indirect_z_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd3) |=> (squash && next_pc == $past(z_ptr)));

  // R5: untaken branch falls through
  assert_untaken_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd1 && status[bit_sel] != want_set) |=>
      (!squash && next_pc == $past(cur_pc) + PC_W'(1)));
endmodule

// File: tb/pcu_branch_unit_tb.sv
module pcu_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  kind;
  logic [15:0] cur_pc;
  logic [7:0]  status;
  logic [2:0]  bit_sel;
  logic        want_set;
  logic [6:0]  br_off;
  logic [11:0] jmp_off;
  logic [15:0] z_ptr;
  logic        skip_req, skip_two;
  logic        out_valid;
  logic [15:0] next_pc;
  logic        squash;

  always #4 clk = ~clk;  // 125 MHz

  pcu_branch_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .cur_pc(cur_pc),
    .status(status), .bit_sel(bit_sel), .want_set(want_set), .br_off(br_off),
    .jmp_off(jmp_off), .z_ptr(z_ptr), .skip_req(skip_req), .skip_two(skip_two),
    .out_valid(out_valid), .next_pc(next_pc), .squash(squash)
  );

  typedef struct {
    logic [15:0] pc;
    logic        sq;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic [15:0] last_pc  = 16'h0;
  bit          done     = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: compute the expected result from the requirements and enqueue it
  task automatic send(input string tag, input logic [1:0] k, input logic [15:0] pc,
                      input logic [7:0] st, input logic [2:0] bs, input logic ws,
                      input logic [6:0] bo, input logic [11:0] jo, input logic [15:0] z,
                      input logic sk, input logic sk2);
    exp_t e;
    int   t;
    @(negedge clk);
    in_valid = 1'b1; kind = k; cur_pc = pc; status = st; bit_sel = bs;
    want_set = ws; br_off = bo; jmp_off = jo; z_ptr = z; skip_req = sk; skip_two = sk2;
    t = int'(pc) + 1;
    e.sq = 1'b0;
    case (k)
      2'd0: if (sk) begin t = int'(pc) + (sk2 ? 3 : 2); e.sq = 1'b1; end
      2'd1: if (st[bs] == ws) begin t = int'(pc) + int'($signed(bo)) + 1; e.sq = 1'b1; end
      2'd2: begin t = int'(pc) + int'($signed(jo)) + 1; e.sq = 1'b1; end
      default: begin t = int'(z); e.sq = 1'b1; end
    endcase
    e.pc  = t[15:0];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R2 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, {15'd0, squash, next_pc}, {15'd0, e.sq, e.pc});
        last_pc = e.pc;
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; kind = 2'd0; cur_pc = 16'h0; status = 8'h0;
    bit_sel = 3'd0; want_set = 1'b0; br_off = 7'd0; jmp_off = 12'd0; z_ptr = 16'h0;
    skip_req = 1'b0; skip_two = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {30'd0, out_valid, squash}, 32'd0);
    check("R1 reset pc", {16'd0, next_pc}, 32'd0);
    rst = 1'b0;

    send("R3 seq", 2'd0, 16'h0100, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R2 back-to-back seq", 2'd0, 16'h0200, 8'hFF, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b0, 1'b0);
    // Equal branch: zero flag is bit 1, polarity set
    send("R4 equal taken +63", 2'd1, 16'h1000, 8'h02, 3'd1, 1'b1, 7'h3F, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R5 equal not taken", 2'd1, 16'h1000, 8'hFD, 3'd1, 1'b1, 7'h3F, 12'd0, 16'h0, 1'b0, 1'b0);
    // Signed greater-or-equal: signed flag is bit 4, polarity clear
    send("R4 ge taken -64", 2'd1, 16'h2000, 8'h00, 3'd4, 1'b0, 7'h40, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R5 ge not taken", 2'd1, 16'h2000, 8'h10, 3'd4, 1'b0, 7'h40, 12'd0, 16'h0, 1'b0, 1'b0);
    // Interrupt enable is bit 7, carry is bit 0
    send("R4 ie taken", 2'd1, 16'h3000, 8'h80, 3'd7, 1'b1, 7'h05, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R4 carry clear taken", 2'd1, 16'h3000, 8'hFE, 3'd0, 1'b0, 7'h7F, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R6 rjmp +2047", 2'd2, 16'h4000, 8'h00, 3'd0, 1'b0, 7'd0, 12'h7FF, 16'h0, 1'b0, 1'b0);
    send("R6 rjmp -2048", 2'd2, 16'h4000, 8'h00, 3'd0, 1'b0, 7'd0, 12'h800, 16'h0, 1'b0, 1'b0);
    send("R7 ijmp", 2'd3, 16'h5000, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'hBEEF, 1'b0, 1'b0);
    send("R8 skip one word", 2'd0, 16'h6000, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b1, 1'b0);
    send("R8 skip two words", 2'd0, 16'h6000, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b1, 1'b1);
    send("R9 skip ignored on ijmp", 2'd3, 16'h7000, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h1234, 1'b1, 1'b1);
    send("R9 skip ignored on untaken", 2'd1, 16'h7000, 8'h00, 3'd2, 1'b1, 7'h10, 12'd0, 16'h0, 1'b1, 1'b1);
    send("R9 skip ignored on rjmp", 2'd2, 16'h7000, 8'h00, 3'd0, 1'b0, 7'd0, 12'h010, 16'h0, 1'b1, 1'b0);
    send("R10 seq wrap", 2'd0, 16'hFFFF, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R10 skip wrap", 2'd0, 16'hFFFE, 8'h00, 3'd0, 1'b0, 7'd0, 12'd0, 16'h0, 1'b1, 1'b1);
    send("R10 branch below zero", 2'd1, 16'h0000, 8'h40, 3'd6, 1'b1, 7'h40, 12'd0, 16'h0, 1'b0, 1'b0);
    send("R10 rjmp past top", 2'd2, 16'hFFF0, 8'h00, 3'd0, 1'b0, 7'd0, 12'h7FF, 16'h0, 1'b0, 1'b0);

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 idle flags", {30'd0, out_valid, squash}, 32'd0);
    check("R11 idle pc hold", {16'd0, next_pc}, {16'd0, last_pc});
    @(negedge clk);
    check("R11 idle pc hold 2", {16'd0, next_pc}, {16'd0, last_pc});
    check("R2 scoreboard drained", sb.size(), 32'd0);
    done = 1;
    summary();
  end
endmodule